// File: doc/BRIEF.md
# Satellite Control Tone Source Selector

This block produces the control tone that a satellite receiver places on the supply line of an antenna converter. It derives a nominal 22 kHz square wave with 50 % duty from the system clock, and picks what drives the tone output from two register bits: `tone_en_reg` and `mod_sel_reg`. The choices are a continuous internal tone, the internal tone keyed by the envelope on the `mod_in` pin, or `mod_in` copied straight to the output. Internal bursts always begin on a fresh high half and always end on a period boundary, so no runt pulse reaches the output.

No burst may start while the output-voltage monitor reports `vout_bad`. Once a burst is running it continues whatever the monitor reports, and the status flag seen by software is held at "good" for the whole burst. The block also drives the transmit/receive switch gate and the tone-detector threshold select from a register bit and a pin.

The sequencer has four states. ST_IDLE drives the output low. ST_HIGH and ST_LOW are the two halves of an internal period. ST_PASS copies a high `mod_in`. The transitions are as follows. Idle-to-high is taken when an internal mode requests tone and `vout_bad` is low. Idle-to-pass is taken in pass-through mode when `mod_in` is high and `vout_bad` is low. High-to-low is taken at the end of a half. Low-to-high is taken at the end of a half while tone is still requested. Low-to-idle is taken at the end of a half when tone is no longer requested. Pass-to-idle is taken when `mod_in` falls or the mode leaves pass-through.

Top module: `tone_src_sel`

## Requirements
- R1: While `rst_n` is low, and after it is released with no tone requested, `tone_out` is 0, and `vout_bad_flag` equals `vout_bad`.
- R2: An internal burst period is 2*HALF clock cycles, with `tone_out` high for exactly HALF cycles followed by low for HALF cycles. HALF = round(CLK_HZ / (2*TONE_HZ)).
- R3: With `tone_en_reg`=1, the internal tone runs continuously whatever `mod_sel_reg` and `mod_in` are.
- R4: With `tone_en_reg`=0 and `mod_sel_reg`=0, the internal tone runs only while `mod_in` is high. A started period is always completed.
- R5: With `tone_en_reg`=0 and `mod_sel_reg`=1, `tone_out` equals `mod_in` delayed by one clock cycle, for rising and falling edges alike.
- R6: An internal burst starts with its high half. `tone_out` rises on the first cycle after the edge that samples the request.
- R7: When the request drops, the current period finishes its low half and the output then stays low. No high phase is shorter than HALF cycles.
- R8: While idle with `vout_bad`=1, no burst starts and `vout_bad_flag` reads 1.
- R9: While a burst runs, `vout_bad_flag` reads 0, and a rise of `vout_bad` neither stops nor shortens the burst.
- R10: `tx_switch` is 1 when `tx_sel_pin` or `tx_sel_reg` is 1, and 0 only when both are 0.
- R11: `det_thr_high` (1 selects the 400 mV transmit threshold, 0 the 200 mV receive threshold) is 1 when `tx_sel_pin` or `tx_sel_reg` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_en_reg | input | 1 | Register bit: internal continuous tone |
| mod_sel_reg | input | 1 | Register bit: pass-through of mod_in when tone_en_reg is 0 |
| mod_in | input | 1 | External modulation pin |
| vout_bad | input | 1 | Raw output-voltage out-of-window status |
| tx_sel_reg | input | 1 | Register bit forcing transmit mode |
| tx_sel_pin | input | 1 | Pin requesting transmit mode |
| tone_out | output | 1 | Tone drive |
| vout_bad_flag | output | 1 | Status flag, held 0 during a burst |
| tx_switch | output | 1 | Transmit switch gate |
| det_thr_high | output | 1 | Detector threshold select, 1 = transmit |

## Verification
The continuous mode is run with `mod_sel_reg` set and `mod_in` toggling, which shows that neither input reaches the output. It is stopped in the middle of a high half, which separates a period-boundary stop from a truncating stop. The keyed mode is tried with a short envelope and with a long one: both round up to whole periods, and the pair separates envelope gating from free running. Pass-through uses uneven high and low lengths to expose asymmetric latency. The fault pattern holds `vout_bad` before a burst and raises it during one, which separates blocking at start from mid-burst abort and from flag latching.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        SRC_KEYED,
        SRC_PASS,
        SRC_CONT
    } tone_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_PASS
    } tone_st_e;

    // rounded clock cycles per half tone period
    function automatic int half_cycles(input int clk_hz, input int tone_hz);
        return (clk_hz + tone_hz) / (2 * tone_hz);
    endfunction

endpackage

// File: rtl/tone_mode_dec.sv
module tone_mode_dec
    import tone_pkg::*;
(
    input  logic      tone_en_reg,
    input  logic      mod_sel_reg,
    output tone_src_e src
);
    always_comb begin
        if (tone_en_reg)
            src = SRC_CONT;      // enable wins over select
        else if (mod_sel_reg)
            src = SRC_PASS;
        else
            src = SRC_KEYED;
    end
endmodule

// File: rtl/tone_half_cnt.sv
module tone_half_cnt #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign half_end = run && (cnt == LAST);
endmodule

// File: rtl/tone_seq.sv
module tone_seq
    import tone_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tone_src_e src,
    input  logic      mod_in,
    input  logic      vout_bad,
    input  logic      half_end,
    output logic      run,
    output logic      tone_out,
    output logic      busy,
    output tone_st_e  st
);
    tone_st_e nxt;
    logic     want;

    assign want = (src == SRC_CONT) || ((src == SRC_KEYED) && mod_in);

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (!vout_bad) begin
                    if (src == SRC_PASS) begin
                        if (mod_in)
                            nxt = ST_PASS;
                    end else if (want) begin
                        nxt = ST_HIGH;
                    end
                end
            end
            ST_HIGH: if (half_end) nxt = ST_LOW;
            ST_LOW:  if (half_end) nxt = want ? ST_HIGH : ST_IDLE;
            ST_PASS: if (src != SRC_PASS || !mod_in) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        run      = 1'b0;
        tone_out = 1'b0;
        busy     = 1'b1;
        unique case (st)
            ST_IDLE: busy = 1'b0;
            ST_HIGH: begin run = 1'b1; tone_out = 1'b1; end
            ST_LOW:  run = 1'b1;
            ST_PASS: tone_out = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/tone_src_sel.sv
module tone_src_sel
    import tone_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TONE_HZ = 22_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_en_reg,
    input  logic mod_sel_reg,
    input  logic mod_in,
    input  logic vout_bad,
    input  logic tx_sel_reg,
    input  logic tx_sel_pin,
    output logic tone_out,
    output logic vout_bad_flag,
    output logic tx_switch,
    output logic det_thr_high
);
    localparam int HALF = half_cycles(CLK_HZ, TONE_HZ);

    tone_src_e src;
    tone_st_e  st;
    logic      run;
    logic      half_end;
    logic      busy;
    logic      tx_mode;

    tone_mode_dec u_dec (
        .tone_en_reg (tone_en_reg),
        .mod_sel_reg (mod_sel_reg),
        .src         (src)
    );

    tone_half_cnt #(.HALF(HALF)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_end (half_end)
    );

    tone_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .mod_in   (mod_in),
        .vout_bad (vout_bad),
        .half_end (half_end),
        .run      (run),
        .tone_out (tone_out),
        .busy     (busy),
        .st       (st)
    );

    // status flag is forced good while a burst is on the line
    assign vout_bad_flag = vout_bad && !busy;

    assign tx_mode      = tx_sel_pin || tx_sel_reg;
    assign tx_switch    = tx_mode;
    assign det_thr_high = tx_mode;
endmodule

// File: rtl/tone_src_sel_chk.sv
module tone_src_sel_chk
    import tone_pkg::*;
#(
    parameter int HALF = 10
) (
    input logic     clk,
    input logic     rst_n,
    input logic     tone_out,
    input logic     vout_bad,
    input logic     vout_bad_flag,
    input logic     mod_in,
    input tone_st_e st
);
    tone_st_e st_q;
    int       hi_run;
    int       lo_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            st_q   <= st;
            hi_run <= (st == ST_HIGH) ? hi_run + 1 : 0;
            lo_run <= (st == ST_LOW)  ? lo_run + 1 : 0;
        end
    end

    // R2 R7
    high_half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && st != ST_HIGH) |-> hi_run == HALF);

    // R2
    low_half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOW && st != ST_LOW) |-> lo_run == HALF);

    // R8
    start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && vout_bad) |=> st == ST_IDLE);

    // R9
    flag_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tone_out |-> !vout_bad_flag);

    // R5
    pass_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS && !mod_in) |=> !tone_out);
endmodule

bind tone_src_sel tone_src_sel_chk #(.HALF(HALF)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tone_out      (tone_out),
    .vout_bad      (vout_bad),
    .vout_bad_flag (vout_bad_flag),
    .mod_in        (mod_in),
    .st            (st)
);

// File: tb/sim_tone_src_sel.sv
`timescale 1ns/1ps
module sim_tone_src_sel;
    localparam int CLK_HZ  = 440_000;
    localparam int TONE_HZ = 22_000;
    localparam int HALF    = 10;   // round(440000 / 44000)

    typedef struct {
        logic  val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tone_en_reg = 1'b0, mod_sel_reg = 1'b0, mod_in = 1'b0, vout_bad = 1'b1;
    logic tx_sel_reg = 1'b0, tx_sel_pin = 1'b0;
    logic tone_out, vout_bad_flag, tx_switch, det_thr_high;

    int   checks = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    tone_src_sel #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .tone_en_reg(tone_en_reg), .mod_sel_reg(mod_sel_reg),
        .mod_in(mod_in), .vout_bad(vout_bad), .tx_sel_reg(tx_sel_reg), .tx_sel_pin(tx_sel_pin),
        .tone_out(tone_out), .vout_bad_flag(vout_bad_flag), .tx_switch(tx_switch),
        .det_thr_high(det_thr_high)
    );

    task automatic push(input logic v, input int n, input string tag);
        for (int i = 0; i < n; i++) q.push_back('{val: v, tag: tag});
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        step(1);
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: compare tone_out against the scoreboard queue
    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            check(tone_out, e.val, e.tag);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(3);
        check(tone_out, 1'b0, "R1 tone in reset");
        check(vout_bad_flag, 1'b1, "R1 flag in reset");
        rst_n = 1'b1;
        step(2);
        check(tone_out, 1'b0, "R1 tone after reset");
        check(vout_bad_flag, 1'b1, "R1 flag after reset");
        vout_bad = 1'b0;
        step(1);
        check(vout_bad_flag, 1'b0, "R1 flag follows monitor");

        // R3 R2 R6 R7: continuous, select and pin toggling ignored, stop mid high half
        mod_sel_reg = 1'b1; tone_en_reg = 1'b1;
        push(0, 1, "R6 start latency");
        for (int p = 0; p < 2; p++) begin
            push(1, HALF, "R2 R3 high half");
            push(0, HALF, "R2 R3 low half");
        end
        push(0, 5, "R7 stays low after stop");
        step(5);  mod_in = 1'b1;
        step(20); tone_en_reg = 1'b0; mod_in = 1'b0; mod_sel_reg = 1'b0;
        drain();

        // R4 short envelope rounds up to one period
        mod_in = 1'b1;
        push(0, 1, "R4 start");
        push(1, HALF, "R4 keyed high");
        push(0, HALF + 5, "R4 keyed end");
        step(13); mod_in = 1'b0;
        drain();

        // R4 longer envelope gives two periods
        mod_in = 1'b1;
        push(0, 1, "R4 start long");
        for (int p = 0; p < 2; p++) begin
            push(1, HALF, "R4 long high");
            push(0, HALF, "R4 long low");
        end
        push(0, 5, "R4 long end");
        step(31); mod_in = 1'b0;
        drain();

        // R5 pass-through with uneven lengths
        mod_sel_reg = 1'b1;
        step(2);
        mod_in = 1'b1;
        push(0, 1, "R5 lag");
        push(1, 7, "R5 high a");
        push(0, 4, "R5 low a");
        push(1, 3, "R5 high b");
        push(0, 5, "R5 low b");
        step(7); mod_in = 1'b0;
        step(4); mod_in = 1'b1;
        step(3); mod_in = 1'b0;
        drain();
        mod_sel_reg = 1'b0;
        step(2);

        // R8 blocked start, R9 latched flag during burst
        vout_bad = 1'b1; tone_en_reg = 1'b1;
        push(0, 30, "R8 tone blocked");
        step(30);
        check(vout_bad_flag, 1'b1, "R8 flag while blocked");
        vout_bad = 1'b0;
        push(0, 1, "R8 release latency");
        for (int p = 0; p < 2; p++) begin
            push(1, HALF, "R9 high half");
            push(0, HALF, "R9 low half");
        end
        push(0, 5, "R9 end");
        step(5); vout_bad = 1'b1;
        step(1);
        check(vout_bad_flag, 1'b0, "R9 flag held during burst");
        step(20); tone_en_reg = 1'b0;
        drain();
        check(vout_bad_flag, 1'b1, "R8 flag after burst");
        vout_bad = 1'b0;
        step(1);

        // R10 R11 transmit control
        for (int k = 0; k < 4; k++) begin
            tx_sel_reg = k[0];
            tx_sel_pin = k[1];
            step(1);
            check(tx_switch, k[0] | k[1], "R10 tx switch");
            check(det_thr_high, k[0] | k[1], "R11 threshold select");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule